// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Controller

This block gathers 32 interrupt request lines, already synchronized to its clock, and turns them into two processor requests: a normal request and a fast request. Each line can be set to detect a level or an edge. For each line, a polarity bit selects either active-high or active-low for a level, or rising or falling for an edge. An edge event is held in a sticky bit until software clears it with a write-one-to-clear access. A mask removes lines from consideration. A per-line steering bit sends each unmasked pending line to one of the two outputs.

Software reaches the block through a single-cycle read/write port. Writes take effect on the next clock edge. Read data is combinational from the address. A helper output gives the lowest-numbered source that is pending and unmasked, so a handler can dispatch without scanning the status word. The asynchronous reset is synchronized inside the block, so its release takes effect on a clock edge.

Top module: `intr_trig_ctrl`

## Requirements
- R1: After reset the trigger-select (address 0), polarity (address 1) and route (address 3) registers read zero, the mask (address 2) reads all ones, all edge latches are clear, and irq_o, fiq_o and next_vld are 0.
- R2: For a source whose trigger-select bit is 0 (level), its status bit equals the live input XOR its polarity bit: polarity 0 is active-high and polarity 1 is active-low. The status bit follows the input in the same cycle.
- R3: For a source whose trigger-select bit is 1 (edge), a rising edge (polarity 0) or a falling edge (polarity 1) sets its latch one clock after the input changes. The latch stays set after the input returns, and its status bit shows the latch.
- R4: Writing to address 4 clears the edge latches at the bit positions written as 1 and leaves the other latches as they are. Address 4 reads zero.
- R5: If an edge arrives in the same cycle as a clear write to that bit, the latch ends up set.
- R6: Pending equals status AND NOT mask: a mask bit of 1 blocks that source from irq_o, fiq_o and next_id. Address 6 reads the pending word and address 5 reads the status word.
- R7: irq_o is the OR of the pending bits whose route bit is 0, and fiq_o is the OR of the pending bits whose route bit is 1.
- R8: next_id is the lowest-numbered pending bit and next_vld is 1. When nothing is pending, next_vld is 0 and next_id is all ones.
- R9: Addresses 0 to 3 read back the last value written to them.
- R10: An edge seen while a source is in level mode is not latched, so switching the source to edge mode afterwards shows status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Synchronized interrupt request lines |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data for bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| next_vld | output | 1 | Some source is pending and unmasked |
| next_id | output | $clog2(NUM_SRC) | Lowest pending unmasked source |

## Verification
The hardest case to reach from the ports is a clear write that lands in the exact clock cycle in which a new edge arrives on the same bit. Here the edge has to win. The directed sequence lines up the input transition and the clear strobe on the same falling clock edge. The random phase, which mixes input toggles with random clear masks, produces many more such collisions. It also covers trigger-mode changes while edges are in flight, which is how the rule that edges in level mode are not latched gets exercised.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] RA_TRIG  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_POL   = 3'd1;
  localparam logic [ADDR_W-1:0] RA_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_ROUTE = 3'd3;
  localparam logic [ADDR_W-1:0] RA_CLR   = 3'd4;
  localparam logic [ADDR_W-1:0] RA_STAT  = 3'd5;
  localparam logic [ADDR_W-1:0] RA_PEND  = 3'd6;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/intc_edge_det.sv
module intc_edge_det #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_in,
  input  logic [N-1:0] trig_edge,
  input  logic [N-1:0] pol_inv,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] edge_hit,
  output logic [N-1:0] edge_lat,
  output logic [N-1:0] status
);
  logic [N-1:0] in_q;
  logic [N-1:0] lat_nxt;
  logic         lat_en;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      edge_hit[i] = trig_edge[i] &
                    (pol_inv[i] ? (in_q[i] & ~src_in[i]) : (src_in[i] & ~in_q[i]));
    end
    lat_nxt = (edge_lat & ~clr_vec) | edge_hit;
    lat_en  = (|clr_vec) | (|edge_hit);
    status  = (trig_edge & edge_lat) | (~trig_edge & (src_in ^ pol_inv));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q     <= '0;
      edge_lat <= '0;
    end else begin
      in_q <= src_in;
      if (lat_en) edge_lat <= lat_nxt;
    end
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  input  logic [N-1:0]      status,
  input  logic [N-1:0]      pending,
  output logic [N-1:0]      bus_rdata,
  output logic [N-1:0]      trig_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      route_q,
  output logic [N-1:0]      clr_vec
);
  logic we_trig, we_pol, we_mask, we_route;

  always_comb begin
    we_trig  = bus_wr && (bus_addr == RA_TRIG);
    we_pol   = bus_wr && (bus_addr == RA_POL);
    we_mask  = bus_wr && (bus_addr == RA_MASK);
    we_route = bus_wr && (bus_addr == RA_ROUTE);
    clr_vec  = (bus_wr && (bus_addr == RA_CLR)) ? bus_wdata : '0;
    case (bus_addr)
      RA_TRIG:  bus_rdata = trig_q;
      RA_POL:   bus_rdata = pol_q;
      RA_MASK:  bus_rdata = mask_q;
      RA_ROUTE: bus_rdata = route_q;
      RA_STAT:  bus_rdata = status;
      RA_PEND:  bus_rdata = pending;
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '1;
      route_q <= '0;
    end else begin
      if (we_trig)  trig_q  <= bus_wdata;
      if (we_pol)   pol_q   <= bus_wdata;
      if (we_mask)  mask_q  <= bus_wdata;
      if (we_route) route_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int N    = 32,
  parameter int ID_W = $clog2(N)
) (
  input  logic [N-1:0]    pending,
  output logic            vld,
  output logic [ID_W-1:0] id
);
  always_comb begin
    vld = |pending;
    id  = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (pending[i]) id = ID_W'(i);
    end
  end
endmodule

// File: rtl/intr_trig_ctrl.sv
module intr_trig_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_o,
  output logic               fiq_o,
  output logic               next_vld,
  output logic [ID_W-1:0]    next_id
);
  logic               rst_core_n;
  logic [NUM_SRC-1:0] trig_q, pol_q, mask_q, route_q, clr_vec;
  logic [NUM_SRC-1:0] edge_hit, edge_lat, status, pending;

  intc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n));

  intc_edge_det #(.N(NUM_SRC)) u_det (
    .clk(clk), .rst_n(rst_core_n), .src_in(src_in), .trig_edge(trig_q),
    .pol_inv(pol_q), .clr_vec(clr_vec), .edge_hit(edge_hit),
    .edge_lat(edge_lat), .status(status)
  );

  intc_regs #(.N(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .status(status), .pending(pending),
    .bus_rdata(bus_rdata), .trig_q(trig_q), .pol_q(pol_q), .mask_q(mask_q),
    .route_q(route_q), .clr_vec(clr_vec)
  );

  assign pending = status & ~mask_q;
  assign irq_o   = |(pending & ~route_q);
  assign fiq_o   = |(pending & route_q);

  intc_prio #(.N(NUM_SRC), .ID_W(ID_W)) u_prio (
    .pending(pending), .vld(next_vld), .id(next_id)
  );
endmodule

// File: rtl/intr_trig_ctrl_chk.sv
module intr_trig_ctrl_chk #(
  parameter int N    = 32,
  parameter int ID_W = $clog2(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_o,
  input logic            fiq_o,
  input logic            next_vld,
  input logic [ID_W-1:0] next_id,
  input logic [N-1:0]    edge_lat,
  input logic [N-1:0]    edge_hit,
  input logic [N-1:0]    clr_vec
);
  AST_NONE_ID: assert property (@(posedge clk) disable iff (!rst_n)
    !next_vld |-> (next_id == '1)); // R8
  AST_OUT_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> next_vld); // R7
  AST_SRC_HAS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    next_vld |-> (irq_o || fiq_o)); // R6
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(edge_lat) & ~edge_lat) & ~$past(clr_vec)) == '0)); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((edge_lat & $past(clr_vec) & ~$past(edge_hit)) == '0)); // R4
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> (($past(edge_hit) & ~edge_lat) == '0)); // R5
endmodule

bind intr_trig_ctrl intr_trig_ctrl_chk #(.N(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .fiq_o(fiq_o),
  .next_vld(next_vld), .next_id(next_id), .edge_lat(edge_lat),
  .edge_hit(edge_hit), .clr_vec(clr_vec)
);

// File: tb/intr_trig_ctrl_bench.sv
`timescale 1ns/1ps
module intr_trig_ctrl_bench;
  localparam int N  = 32;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_in;
  logic          bus_wr;
  logic [2:0]    bus_addr;
  logic [N-1:0]  bus_wdata;
  logic [N-1:0]  bus_rdata;
  logic          irq_o, fiq_o, next_vld;
  logic [IW-1:0] next_id;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  logic [N-1:0] m_trig, m_pol, m_mask, m_route, m_lat, m_prev;

  always #2.5 clk = ~clk;

  intr_trig_ctrl u_intr_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .next_vld(next_vld), .next_id(next_id)
  );

  // Reference model of the register state
  always @(posedge clk) begin
    if (!rst_n) begin
      m_trig <= '0; m_pol <= '0; m_mask <= '1; m_route <= '0;
      m_lat <= '0; m_prev <= '0;
    end else begin
      logic [N-1:0] hit, clr;
      hit = m_trig & ((~m_pol & src_in & ~m_prev) | (m_pol & ~src_in & m_prev));
      clr = (bus_wr && bus_addr == 3'd4) ? bus_wdata : '0;
      m_lat  <= (m_lat & ~clr) | hit;
      m_prev <= src_in;
      if (bus_wr && bus_addr == 3'd0) m_trig  <= bus_wdata;
      if (bus_wr && bus_addr == 3'd1) m_pol   <= bus_wdata;
      if (bus_wr && bus_addr == 3'd2) m_mask  <= bus_wdata;
      if (bus_wr && bus_addr == 3'd3) m_route <= bus_wdata;
    end
  end

  function automatic logic [N-1:0] exp_status();
    return (m_trig & m_lat) | (~m_trig & (src_in ^ m_pol));
  endfunction

  function automatic logic [N-1:0] exp_pend();
    return exp_status() & ~m_mask;
  endfunction

  function automatic logic [IW:0] exp_next(logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return {1'b1, IW'(i)};
    return {1'b0, {IW{1'b1}}};
  endfunction

  task automatic chk(string req, logic [N-1:0] got, logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, string req, logic [N-1:0] exp);
    bus_addr = a;
    #0.5;
    chk(req, bus_rdata, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_outs(string req);
    logic [N-1:0] p;
    logic [IW:0]  nx;
    p  = exp_pend();
    nx = exp_next(p);
    chk({req, " irq"},  N'(irq_o), N'(|(p & ~m_route)));
    chk({req, " fiq"},  N'(fiq_o), N'(|(p & m_route)));
    chk({req, " next"}, N'({next_vld, next_id}), N'(nx));
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    rst_n = 1'b0; src_in = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(3'd0, "R1 trig", '0);
    rd(3'd1, "R1 pol", '0);
    rd(3'd2, "R1 mask", '1);
    rd(3'd3, "R1 route", '0);
    rd(3'd5, "R1 status", '0);
    chk("R1 outs", N'({irq_o, fiq_o, next_vld}), '0);
    chk("R8 none id", N'(next_id), N'(5'd31));

    // R9 readback
    wr(3'd1, 32'hA5A5_0F0F); rd(3'd1, "R9 pol", 32'hA5A5_0F0F);
    wr(3'd3, 32'h1234_5678); rd(3'd3, "R9 route", 32'h1234_5678);
    wr(3'd1, '0); wr(3'd3, '0);

    // R2 level mode
    wr(3'd2, '0);
    @(negedge clk); src_in = 32'h0000_0020;
    rd(3'd5, "R2 active-high", 32'h0000_0020);
    chk_outs("R2");
    wr(3'd1, 32'h0000_0020);
    rd(3'd5, "R2 high input low-active", '0);
    src_in = '0;
    rd(3'd5, "R2 active-low", 32'h0000_0020);
    chk_outs("R2b");
    wr(3'd1, '0);

    // R3 edge mode, rising and falling
    wr(3'd0, '1); wr(3'd4, '1);
    wr(3'd1, 32'h0000_0080);
    @(negedge clk); src_in = 32'h0000_0088;
    @(negedge clk); rd(3'd5, "R3 rise latched, fall idle", 32'h0000_0008);
    src_in = 32'h0000_0080;
    @(negedge clk); rd(3'd5, "R3 rise held", 32'h0000_0008);
    src_in = '0;
    @(negedge clk); rd(3'd5, "R3 fall latched", 32'h0000_0088);
    chk_outs("R3");

    // R4 clear
    wr(3'd4, 32'h0000_0008);
    rd(3'd5, "R4 selective clear", 32'h0000_0080);
    rd(3'd4, "R4 clear reads zero", '0);

    // R5 edge vs clear collision on bit 9
    @(negedge clk);
    src_in = 32'h0000_0200; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h0000_0200;
    @(negedge clk); bus_wr = 1'b0;
    rd(3'd5, "R5 edge wins", 32'h0000_0280);

    // R10 edges in level mode are not latched
    wr(3'd0, ~32'h0000_1000);
    @(negedge clk); src_in = 32'h0000_1200;
    @(negedge clk); src_in = 32'h0000_0200;
    wr(3'd0, '1);
    rd(3'd5, "R10 no latch in level", 32'h0000_0280);

    // R6 mask, R7 routing, R8 lowest
    wr(3'd2, 32'h0000_0080);
    rd(3'd6, "R6 pending masked", 32'h0000_0200);
    chk("R8 lowest", N'(next_id), N'(5'd9));
    wr(3'd2, '0);
    chk("R8 lowest two", N'(next_id), N'(5'd7));
    wr(3'd3, 32'h0000_0080);
    chk("R7 split", N'({irq_o, fiq_o}), N'(2'b11));
    wr(3'd3, 32'h0000_0280);
    chk("R7 all fiq", N'({irq_o, fiq_o}), N'(2'b01));
    chk_outs("R7");

    // Random phase
    for (int it = 0; it < 2000; it++) begin
      @(negedge clk);
      chk_outs("R6/R7/R8 rnd");
      bus_addr = 3'd5; #0.5; chk("R2/R3/R5 rnd status", bus_rdata, exp_status());
      src_in ^= ($urandom % 4 == 0) ? $urandom : ($urandom & 32'h0000_00FF);
      bus_wr = ($urandom % 3 == 0);
      bus_addr = 3'($urandom % 5);
      bus_wdata = ($urandom % 2) ? $urandom : ($urandom & $urandom);
    end
    @(negedge clk); bus_wr = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule